// File: doc/BRIEF.md
# Data Latch Literal Loader

This block holds a dock's word-wide data latch and the hidden literal staging register in front of it. An instruction that carries a literal presents its immediate, its mode and its sign bit when it comes on deck. The block stages these values. When that instruction later executes, the staged literal is written into the data latch. The latch can also be loaded whole from the incoming data word by a capture strobe.

There are two literal modes. The first shifts a 19-bit immediate into the bottom of the latch and moves the older low bits upward, so a wide constant can be built from several instructions in a row. The second writes a 14-bit immediate and fills every bit above it with a separate sign bit.

The staging register is controlled by a two-state machine. ST_EMPTY is the reset state. Transition STAGE (ST_EMPTY to ST_HELD) happens on an on-deck strobe. Transition CONSUME (ST_HELD to ST_EMPTY) happens on an execute that is not overridden by a capture. Transition DROP (ST_HELD to ST_EMPTY) happens on a cancel.

Top module: `data_latch_loader`

## Requirements
- R1: After reset, `latch_q` is all zeros, the staging register is empty (`od_ready`=1) and `ex_err`=0.
- R2: An on-deck strobe is taken only while `od_ready`=1. It stores `od_mode`, `od_imm` and `od_sign` and clears `od_ready` after the edge. By itself it leaves `latch_q` unchanged.
- R3: Executing a staged literal with `od_mode`=0 (shift) sets `latch_q` to {old `latch_q`[17:0], imm[18:0]}. The old bits [36:18] are lost.
- R4: Executing a staged literal with `od_mode`=1 (sign load) sets `latch_q`[13:0] to imm[13:0] and every bit in [36:14] to the staged sign bit. imm[18:14] have no effect.
- R5: An execute that uses the staged literal empties the staging register, so `od_ready`=1 after the edge.
- R6: An execute with nothing staged, and no capture in the same cycle, leaves `latch_q` unchanged. It makes `ex_err`=1 for exactly the following cycle.
- R7: A capture strobe loads `latch_q` with `cap_data` on the next edge. This happens even when an execute arrives in the same cycle. The staged literal then stays held and no error is raised.
- R8: A cancel while a literal is held empties the staging register and leaves `latch_q` unchanged. If an execute arrives in the same cycle as the cancel, the execute is applied.
- R9: An on-deck strobe while a literal is held is ignored. The next execute uses the earlier literal.
- R10: Two shift executes in a row build {imm1[17:0], imm2[18:0]} in the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| od_valid | input | 1 | Literal instruction comes on deck |
| od_mode | input | 1 | 0 = shift-in, 1 = sign-extended load |
| od_imm | input | 19 | Immediate field |
| od_sign | input | 1 | Fill bit for sign-extended load |
| od_cancel | input | 1 | Discard the staged literal |
| od_ready | output | 1 | Staging register is empty |
| ex_valid | input | 1 | Literal instruction executes |
| cap_valid | input | 1 | Capture the data input |
| cap_data | input | 37 | Incoming data word |
| latch_q | output | 37 | Data latch value |
| ex_err | output | 1 | Previous cycle executed with nothing staged |

## Verification
The shift path is driven with alternating-bit and all-ones immediates on top of a known captured word, and then with two chained shifts. This shows whether the old low bits are moved up and the old high bits are dropped. The sign load is run with sign 0 and sign 1, using immediates whose high five bits are set, so any leak of imm[18:14] shows up. Collisions are driven on purpose: capture with execute, cancel with execute, on-deck while held, and execute while empty. These separate the priority order from the staging bookkeeping.

// File: rtl/dll_pkg.sv
package dll_pkg;
    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_SEXT  = 1'b1
    } lit_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } stage_st_e;
endpackage

// File: rtl/lit_stage.sv
module lit_stage
    import dll_pkg::*;
#(
    parameter int IMM_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             od_valid,
    input  lit_mode_e        od_mode,
    input  logic [IMM_W-1:0] od_imm,
    input  logic             od_sign,
    input  logic             od_cancel,
    input  logic             ex_valid,
    input  logic             cap_valid,
    output logic             ready,
    output logic             fire,
    output logic             bad_exec,
    output lit_mode_e        st_mode,
    output logic [IMM_W-1:0] st_imm,
    output logic             st_sign
);
    stage_st_e state, state_nx;
    logic      accept;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (od_valid) state_nx = ST_HELD;                         // STAGE
            ST_HELD:  if ((ex_valid && !cap_valid) || od_cancel) state_nx = ST_EMPTY; // CONSUME / DROP
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        ready    = 1'b0;
        fire     = 1'b0;
        bad_exec = 1'b0;
        accept   = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                ready    = 1'b1;
                accept   = od_valid;
                bad_exec = ex_valid && !cap_valid;
            end
            ST_HELD: fire = ex_valid && !cap_valid;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_mode <= MODE_SHIFT;
            st_imm  <= '0;
            st_sign <= 1'b0;
        end else if (accept) begin
            st_mode <= od_mode;
            st_imm  <= od_imm;
            st_sign <= od_sign;
        end
    end

    AST_HELD_KEEPS_LITERAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !ex_valid && !od_cancel) |=> (state == ST_HELD && $stable(st_imm) && $stable(st_sign))); // R9
    AST_FIRE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ready); // R5
endmodule

// File: rtl/lit_form.sv
module lit_form
    import dll_pkg::*;
#(
    parameter int WORD_W  = 37,
    parameter int SHIFT_W = 19,
    parameter int LOAD_W  = 14
) (
    input  lit_mode_e          mode,
    input  logic [SHIFT_W-1:0] imm,
    input  logic               sign,
    input  logic [WORD_W-1:0]  cur,
    output logic [WORD_W-1:0]  nxt
);
    localparam int KEEP_W = WORD_W - SHIFT_W;
    localparam int FILL_W = WORD_W - LOAD_W;

    always_comb begin
        unique case (mode)
            MODE_SHIFT: nxt = {cur[KEEP_W-1:0], imm};
            MODE_SEXT:  nxt = {{FILL_W{sign}}, imm[LOAD_W-1:0]};
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/data_latch_loader.sv
module data_latch_loader
    import dll_pkg::*;
#(
    parameter int WORD_W  = 37,
    parameter int SHIFT_W = 19,
    parameter int LOAD_W  = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               od_valid,
    input  logic               od_mode,
    input  logic [SHIFT_W-1:0] od_imm,
    input  logic               od_sign,
    input  logic               od_cancel,
    output logic               od_ready,
    input  logic               ex_valid,
    input  logic               cap_valid,
    input  logic [WORD_W-1:0]  cap_data,
    output logic [WORD_W-1:0]  latch_q,
    output logic               ex_err
);
    lit_mode_e          st_mode;
    logic [SHIFT_W-1:0] st_imm;
    logic               st_sign, fire, bad_exec;
    logic [WORD_W-1:0]  formed;

    lit_stage #(.IMM_W(SHIFT_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .od_valid(od_valid),
        .od_mode(lit_mode_e'(od_mode)), .od_imm(od_imm), .od_sign(od_sign),
        .od_cancel(od_cancel), .ex_valid(ex_valid), .cap_valid(cap_valid),
        .ready(od_ready), .fire(fire), .bad_exec(bad_exec),
        .st_mode(st_mode), .st_imm(st_imm), .st_sign(st_sign)
    );

    lit_form #(.WORD_W(WORD_W), .SHIFT_W(SHIFT_W), .LOAD_W(LOAD_W)) u_form (
        .mode(st_mode), .imm(st_imm), .sign(st_sign), .cur(latch_q), .nxt(formed)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            ex_err  <= 1'b0;
        end else begin
            ex_err <= bad_exec;
            if (cap_valid)  latch_q <= cap_data;
            else if (fire)  latch_q <= formed;
        end
    end

    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> (latch_q == $past(cap_data))); // R7
    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ex_err |-> $past(od_ready && ex_valid && !cap_valid)); // R6
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_valid && !(ex_valid && !od_ready)) |=> $stable(latch_q)); // R2
    AST_SHIFT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_mode == MODE_SHIFT) |=> (latch_q[SHIFT_W-1:0] == $past(st_imm))); // R3
endmodule

// File: tb/tb_data_latch_loader.sv
module tb_data_latch_loader;
    localparam int W = 37;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          od_valid = 0, od_mode = 0, od_sign = 0, od_cancel = 0;
    logic [18:0]   od_imm = '0;
    logic          ex_valid = 0, cap_valid = 0;
    logic [W-1:0]  cap_data = '0;
    logic          od_ready, ex_err;
    logic [W-1:0]  latch_q;

    always #10 clk = ~clk;

    data_latch_loader dut (
        .clk(clk), .rst_n(rst_n), .od_valid(od_valid), .od_mode(od_mode),
        .od_imm(od_imm), .od_sign(od_sign), .od_cancel(od_cancel),
        .od_ready(od_ready), .ex_valid(ex_valid), .cap_valid(cap_valid),
        .cap_data(cap_data), .latch_q(latch_q), .ex_err(ex_err)
    );

    typedef struct {
        logic [W-1:0] q;
        logic         err;
        logic         rdy;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0, bad = 0;
    bit   done = 0;

    logic [W-1:0] m_q = '0;
    logic         m_held = 0, m_mode = 0, m_sign = 0;
    logic [18:0]  m_imm = '0;

    task automatic step(input logic ov, input logic md, input logic [18:0] im,
                        input logic sg, input logic cn, input logic ex,
                        input logic cp, input logic [W-1:0] dt, input string tag);
        exp_t e;
        logic err_e;
        @(negedge clk);
        od_valid = ov; od_mode = md; od_imm = im; od_sign = sg;
        od_cancel = cn; ex_valid = ex; cap_valid = cp; cap_data = dt;
        err_e = ex && !cp && !m_held;
        if (cp) m_q = dt;
        else if (ex && m_held)
            m_q = m_mode ? {{23{m_sign}}, m_imm[13:0]} : {m_q[17:0], m_imm};
        if (m_held) begin
            if ((ex && !cp) || cn) m_held = 0;
        end else if (ov) begin
            m_held = 1; m_mode = md; m_imm = im; m_sign = sg;
        end
        e.q = m_q; e.err = err_e; e.rdy = !m_held; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 0, '0, 0, 0, 0, 0, '0, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                total++;
                if (latch_q !== e.q || ex_err !== e.err || od_ready !== e.rdy) begin
                    bad++;
                    $display("FAIL %s: got q=%h err=%b rdy=%b, expected q=%h err=%b rdy=%b",
                             e.tag, latch_q, ex_err, od_ready, e.q, e.err, e.rdy);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        idle("R1 reset state");
        // R2 staging a literal leaves latch alone
        step(1, 0, 19'h2AAAA, 0, 0, 0, 0, '0, "R2 on-deck accepted");
        // R7 capture beats execute; literal stays held
        step(0, 0, '0, 0, 0, 1, 1, 37'h1F_0F0F_1234, "R7 capture wins over execute");
        // R3 shift, R5 staging empties
        step(0, 0, '0, 0, 0, 1, 0, '0, "R3 shift with R5 consume");
        // R6 execute when empty
        step(0, 0, '0, 0, 0, 1, 0, '0, "R6 execute while empty");
        idle("R6 error is one cycle");
        // R4 sign load with sign 1, high imm bits set
        step(1, 1, 19'h7C123, 1, 0, 0, 0, '0, "R4 stage sign load");
        step(0, 0, '0, 0, 0, 1, 0, '0, "R4 sign 1 load");
        step(1, 1, 19'h7FFFF, 0, 0, 0, 0, '0, "R4 stage sign 0");
        step(0, 0, '0, 0, 0, 1, 0, '0, "R4 sign 0 load");
        // R9 on-deck while held ignored
        step(1, 0, 19'h12345, 0, 0, 0, 0, '0, "R9 first literal");
        step(1, 0, 19'h7FFFF, 0, 0, 0, 0, '0, "R9 second on-deck ignored");
        step(0, 0, '0, 0, 0, 1, 0, '0, "R9 execute uses first");
        // R8 cancel
        step(1, 0, 19'h55555, 0, 0, 0, 0, '0, "R8 stage");
        step(0, 0, '0, 0, 1, 0, 0, '0, "R8 cancel drops");
        step(0, 0, '0, 0, 0, 1, 0, '0, "R8 execute after cancel errs");
        step(1, 1, 19'h00ABC, 1, 0, 0, 0, '0, "R8 stage again");
        step(0, 0, '0, 0, 1, 1, 0, '0, "R8 execute with cancel applies");
        // R10 chained shifts
        step(0, 0, '0, 0, 0, 0, 1, 37'h0_0000_0000, "R10 clear");
        step(1, 0, 19'h7FFFF, 0, 0, 0, 0, '0, "R10 stage A");
        step(0, 0, '0, 0, 0, 1, 0, '0, "R10 shift A");
        step(1, 0, 19'h2AAAA, 0, 0, 0, 0, '0, "R10 stage B");
        step(0, 0, '0, 0, 0, 1, 0, '0, "R10 shift B");
        step(0, 0, '0, 0, 0, 1, 1, 37'h15_5555_5555, "R7 capture while empty no error");
        idle("R2 idle hold");
        idle("drain");
        repeat (2) @(posedge clk);
        #6;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule